// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

This block buffers a parallel data bus onto a set of three-state output lines. Each bit passes through one storage element that works in two ways, chosen by the level of `le`. While `le` is high the element is a transparent latch, and the output bus follows the input bus with no clock involved. While `le` is low the element is a rising-edge register clocked by `clk`. The value that was visible when `le` fell stays in place until the next rising edge of `clk` replaces it.

An active-low enable, `oe_n`, sits after the storage. When it is high the output lines are released to high impedance. It does not touch the stored value, which keeps updating while the lines float. A parallel copy of the stored value, `q_mon`, is never three-stated, so the storage can be observed at any time. An asynchronous active-low reset clears the storage to zero. The data path has no handshake: `a_bus` is sampled by level or by edge as the control pins direct, and nothing applies back-pressure.

Top module: `bus_hold_driver`

## Requirements
- R1: While `oe_n` is 1, every bit of `y_bus` is high impedance, whatever `le`, `clk` and `a_bus` do.
- R2: While `le` is 1 (reset released), the stored value equals `a_bus` combinationally, and edges of `clk` change nothing.
- R3: While `le` is 0, a rising edge of `clk` loads the present `a_bus` into storage.
- R4: While `le` is 0 and no rising `clk` edge occurs, changes of `a_bus` and falling edges of `clk` leave the stored value unchanged.
- R5: When `le` falls while `clk` is 1, the value passed through at that moment is kept, with no clock edge needed.
- R6: When `le` falls while `clk` is 0 and `clk` then rises with `le` still 0, the storage takes the `a_bus` value present at that rising edge.
- R7: `oe_n` acts only on the output drivers. Stored data keeps updating while `y_bus` floats and appears on `y_bus` once it is driven again.
- R8: While `rst_n` is 0 the stored value is all zeros, whatever `le` is. Reset does not change how `oe_n` acts.
- R9: `q_mon` always shows the stored value, and while `oe_n` is 0, `y_bus` equals `q_mon`. Width is the parameter `WIDTH` (default 18), and all bits share one `le`, `clk` and `oe_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture strobe; rising edge loads storage while `le` is 0 |
| rst_n | input | 1 | Asynchronous active-low clear of storage |
| le | input | 1 | 1 = transparent latch, 0 = edge-triggered register |
| oe_n | input | 1 | Active-low output enable; 1 releases `y_bus` to high impedance |
| a_bus | input | WIDTH | Input data bus |
| y_bus | output | WIDTH | Three-state output data bus |
| q_mon | output | WIDTH | Always-driven copy of the stored value |

## Verification
Directed sequences separate the two ways of leaving transparency. In one, `le` falls with `clk` high and later changes to `a_bus` must not show. In the other, `le` falls with `clk` low and the next rising edge must pick up a new word, which tells a frozen latch apart from a loaded register. Further sequences move `a_bus` under a steady-high clock, a steady-low clock and falling edges, which exposes any level-sensitive leak into the held value. They also pulse `clk` during transparency, update storage while the outputs float, and assert reset in both modes. An arithmetic sweep of a few hundred mixed steps on an 8-bit instance then compares both outputs against a bench model after every single input change.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;
  parameter int unsigned BDRV_DEF_WIDTH = 18;

  // which internal source feeds the stored value
  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_PASS  = 2'd1,
    SRC_LATCH = 2'd2,
    SRC_REG   = 2'd3
  } bdrv_src_e;
endpackage

// File: rtl/bdrv_store.sv
module bdrv_store
  import bdrv_pkg::*;
#(
  parameter int unsigned WIDTH = BDRV_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] reg_q;
  logic             reg_newer;
  bdrv_src_e        src;

  // level-sensitive half: follows d while le is high, freezes when le falls
  always_latch begin
    if (!rst_n)   lat_q <= '0;
    else if (le)  lat_q <= d;
  end

  // edge half: loads on clk rise only while le is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   reg_q <= '0;
    else if (!le) reg_q <= d;
  end

  // marks that a clocked load happened after the last transparent phase
  always_ff @(posedge clk or posedge le or negedge rst_n) begin
    if (!rst_n)   reg_newer <= 1'b0;
    else if (le)  reg_newer <= 1'b0;
    else          reg_newer <= 1'b1;
  end

  always_comb begin
    if (!rst_n)         src = SRC_ZERO;
    else if (le)        src = SRC_PASS;
    else if (reg_newer) src = SRC_REG;
    else                src = SRC_LATCH;
  end

  always_comb begin
    unique case (src)
      SRC_PASS:  q = d;
      SRC_LATCH: q = lat_q;
      SRC_REG:   q = reg_q;
      default:   q = '0;
    endcase
  end
endmodule

// File: rtl/bdrv_tri_out.sv
module bdrv_tri_out #(
  parameter int unsigned WIDTH = bdrv_pkg::BDRV_DEF_WIDTH
) (
  input  logic             en_n,
  input  logic [WIDTH-1:0] d,
  output wire  [WIDTH-1:0] pad
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pad[i] = en_n ? 1'bz : d[i];
  end
endmodule

// File: rtl/bus_hold_driver.sv
module bus_hold_driver
  import bdrv_pkg::*;
#(
  parameter int unsigned WIDTH = BDRV_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] a_bus,
  output wire  [WIDTH-1:0] y_bus,
  output logic [WIDTH-1:0] q_mon
);
  logic [WIDTH-1:0] stored;

  bdrv_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .le    (le),
    .d     (a_bus),
    .q     (stored)
  );

  bdrv_tri_out #(.WIDTH(WIDTH)) u_drv (
    .en_n (oe_n),
    .d    (stored),
    .pad  (y_bus)
  );

  assign q_mon = stored;
endmodule

// File: rtl/bdrv_chk.sv
module bdrv_chk #(
  parameter int unsigned WIDTH = bdrv_pkg::BDRV_DEF_WIDTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             le,
  input logic             oe_n,
  input logic [WIDTH-1:0] a_bus,
  input wire  [WIDTH-1:0] y_bus,
  input logic [WIDTH-1:0] q_mon
);
  // set when le went high or reset hit since the last clk rise
  logic skip_load;
  always_ff @(posedge clk or posedge le or negedge rst_n) begin
    if (!rst_n)  skip_load <= 1'b1;
    else if (le) skip_load <= 1'b1;
    else         skip_load <= 1'b0;
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> (q_mon == a_bus)) else $error("pass-through mismatch"); // R2

  AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (skip_load || q_mon == $past(a_bus))) else $error("edge load lost"); // R3

  AST_DRIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (y_bus == q_mon)) else $error("driven bus differs from storage"); // R9

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RST_ZERO: assert (q_mon == '0) else $error("storage not cleared"); // R8
    end
  end
endmodule

bind bus_hold_driver bdrv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .le    (le),
  .oe_n  (oe_n),
  .a_bus (a_bus),
  .y_bus (y_bus),
  .q_mon (q_mon)
);

// File: tb/bus_hold_driver_test.sv
`timescale 1ns/1ps
module bus_hold_driver_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         le = 1'b0;
  logic         oe_n = 1'b0;
  logic [W-1:0] a_bus = '0;
  tri0  [W-1:0] y_net;
  logic [W-1:0] q_mon;

  logic [W-1:0] ref_q = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bus_hold_driver #(.WIDTH(W)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .le    (le),
    .oe_n  (oe_n),
    .a_bus (a_bus),
    .y_bus (y_net),
    .q_mon (q_mon)
  );

  // released bus reads as zero through the pull-down net
  task automatic check(input string tag);
    logic [W-1:0] exp_y;
    checks++;
    if (q_mon !== ref_q) begin
      errors++;
      $display("FAIL %s q_mon actual %h expected %h", tag, q_mon, ref_q);
    end
    exp_y = oe_n ? '0 : ref_q;
    checks++;
    if (y_net !== exp_y) begin
      errors++;
      $display("FAIL %s y_bus actual %h expected %h", tag, y_net, exp_y);
    end
  endtask

  task automatic set_a(input logic [W-1:0] v);
    a_bus = v;
    if (rst_n && le) ref_q = v;
    #1;
  endtask

  task automatic set_le(input logic v);
    le = v;
    if (rst_n && v) ref_q = a_bus;
    #1;
  endtask

  task automatic set_oe_n(input logic v);
    oe_n = v;
    #1;
  endtask

  task automatic set_rst_n(input logic v);
    rst_n = v;
    if (!v) ref_q = '0;
    else if (le) ref_q = a_bus;
    #1;
  endtask

  task automatic clk_fall();
    clk = 1'b0;
    #2.5;
  endtask

  task automatic clk_rise();
    if (clk) clk_fall();
    clk = 1'b1;
    if (rst_n && !le) ref_q = a_bus;
    #2.5;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R8: reset clears storage, le has no effect during reset
    a_bus = 8'h5A;
    #2;
    check("R8 reset state");
    set_le(1'b1);
    check("R8 le high in reset");
    set_le(1'b0);
    set_rst_n(1'b1);
    check("R8 after release");

    // R2: transparency, clk ignored
    set_le(1'b1);
    set_a(8'h3C);
    check("R2 pass 3C");
    set_a(8'hC3);
    check("R2 pass C3");
    clk_rise();
    check("R2 clk rise ignored");
    clk_fall();
    check("R2 clk fall ignored");

    // R5: le falls with clk high
    set_a(8'h11);
    clk_rise();
    set_le(1'b0);
    check("R5 keep at le fall");
    set_a(8'h22);
    check("R5 later a ignored");
    clk_fall();
    check("R4 falling clk no load");

    // R6: le falls with clk low, then a rising edge
    set_le(1'b1);
    set_a(8'h44);
    set_le(1'b0);
    check("R6 frozen 44");
    set_a(8'h55);
    check("R4 steady low ignores a");
    clk_rise();
    check("R6 rising edge loads 55");

    // R4: clk steady high, a moving
    set_a(8'h0F);
    check("R4 steady high a 0F");
    set_a(8'hF0);
    check("R4 steady high a F0");

    // R3: successive edges
    set_a(8'hA1); clk_rise(); check("R3 load A1");
    set_a(8'hB2); clk_rise(); check("R3 load B2");
    set_a(8'h00); clk_rise(); check("R3 load 00");
    set_a(8'hFF); clk_rise(); check("R3 load FF");

    // R1 and R7: outputs released, storage keeps updating
    set_oe_n(1'b1);
    check("R1 released with FF stored");
    set_a(8'h77);
    clk_rise();
    check("R7 load while released");
    set_le(1'b1);
    set_a(8'h9E);
    check("R1 transparent while released");
    set_le(1'b0);
    set_oe_n(1'b0);
    check("R7 driven again shows 9E");

    // R8: reset mid-run in both modes
    set_rst_n(1'b0);
    check("R8 async clear");
    clk_rise();
    check("R8 edge during reset");
    set_rst_n(1'b1);
    set_le(1'b1);
    set_a(8'h6D);
    set_rst_n(1'b0);
    check("R8 clear while transparent");
    set_rst_n(1'b1);
    check("R8 release transparent");
    set_le(1'b0);

    // R9: arithmetic sweep over mixed steps
    for (int i = 0; i < 300; i++) begin
      int sel;
      sel = (i * 7 + 3) % 6;
      case (sel)
        0: set_a(W'(i * 73 + 29));
        1: set_le(~le);
        2: clk_rise();
        3: clk_fall();
        4: set_oe_n(~oe_n);
        default: set_a(W'(i * 151 + 5));
      endcase
      check("R9 sweep");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule